// File: doc/BRIEF.md
# Cascadable Register Comparator Slice

This block is one byte-wide slice of a register that sits on a bidirectional parallel bus. It holds a value, takes a value from the bus, shifts serially from the most significant end toward the least significant end, or places its contents on the bus. A two-bit select picks the operation. Each register update happens on the rising clock edge.

A comparator continuously weighs the stored byte against the byte present on the bus. The comparison is unsigned or two's-complement, as a mode input selects. The result appears on three open-drain style status lines (equal, greater, less). On these lines 1 means released and 0 means pulled low, so the lines of several slices can be wired-AND together. A separate drive-enable is brought out for each line, so an outer model can build the wired-AND.

For wider words, slices are chained from the most significant to the least significant. The serial input also acts as a priority input. The serial output also acts as an equality output that passes priority down the chain. An active-low status enable releases all three status lines.

Top module: `regcmp_slice`

## Requirements
- R1: A synchronous active-low reset clears the register to zero at the rising edge.
- R2: With select 00 (hold), the register keeps its value across clock edges, whatever is on the bus.
- R3: With select 10 (shift), each edge moves the register one place toward bit 0 and loads the serial input into the top bit. In this mode the cascade output shows register bit 0.
- R4: With select 11 (load), the register takes the bus input value at the edge.
- R5: With select 01 (read), the bus drive enable is 1 and the bus output carries the register. In every other mode the drive enable is 0.
- R6: When status enable (active low) is 1, the equal, greater and less lines all read 1.
- R7: When status is enabled and the cascade input is 0, the greater and less lines read 1. The equal line reads 1 only if the register equals the bus.
- R8: When status is enabled and the cascade input is 1, the lines (equal, greater, less) read as follows: 0,1,0 if the register is greater; 1,0,0 if the two are equal; 0,0,1 if the register is less.
- R9: Mode input 0 compares unsigned; mode input 1 compares as two's complement (bit 7 is the sign).
- R10: Outside shift mode, the cascade output is 1 exactly when the cascade input is 1 and the register equals the bus.
- R11: Each status line's drive enable is the inverse of the line's value: it drives low only when the line reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_sel | input | 2 | Operation: 00 hold, 01 read, 10 shift, 11 load |
| bus_in | input | 8 | Value seen on the parallel bus |
| bus_out | output | 8 | Value driven onto the bus |
| bus_oe | output | 1 | Bus drive enable (read mode only) |
| chain_in | input | 1 | Serial data in / priority in |
| chain_out | output | 1 | Serial data out / equality out |
| stat_en_n | input | 1 | Status enable, active low |
| signed_mode | input | 1 | 1 selects two's-complement compare |
| eq_o | output | 1 | Equal line, 1 = released |
| gt_o | output | 1 | Register greater line, 1 = released |
| lt_o | output | 1 | Register less line, 1 = released |
| eq_drv | output | 1 | Pull-low enable for the equal line |
| gt_drv | output | 1 | Pull-low enable for the greater line |
| lt_drv | output | 1 | Pull-low enable for the less line |

## Verification
On every cycle the assertions check the register transitions for hold, shift and load. They also check that, when the slice has priority, exactly one status line reads 1, that a low priority input keeps the greater and less lines off the wire, and that a high equality output implies register and bus match. The bench scenarios show what a cycle-local property cannot: the reset value, the exact status codes for signed and unsigned operands at the sign boundary, and the serial shift sequence seen through the cascade output and the read path.

// File: rtl/regcmp_slice.sv
module regcmp_slice #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       op_sel,
  input  logic [WIDTH-1:0] bus_in,
  output logic [WIDTH-1:0] bus_out,
  output logic             bus_oe,
  input  logic             chain_in,
  output logic             chain_out,
  input  logic             stat_en_n,
  input  logic             signed_mode,
  output logic             eq_o,
  output logic             gt_o,
  output logic             lt_o,
  output logic             eq_drv,
  output logic             gt_drv,
  output logic             lt_drv
);

  localparam logic [1:0] OP_HOLD  = 2'b00;
  localparam logic [1:0] OP_READ  = 2'b01;
  localparam logic [1:0] OP_SHIFT = 2'b10;
  localparam logic [1:0] OP_LOAD  = 2'b11;
  localparam int         MSB      = WIDTH - 1;

  logic [WIDTH-1:0] store_q;
  logic [WIDTH-1:0] key_reg, key_bus;
  logic             same, above;

  always_ff @(posedge clk) begin
    if (!rst_n)
      store_q <= '0;
    else
      case (op_sel)
        OP_SHIFT: store_q <= {chain_in, store_q[MSB:1]};
        OP_LOAD:  store_q <= bus_in;
        default:  store_q <= store_q;
      endcase
  end

  assign bus_out = store_q;
  assign bus_oe  = (op_sel == OP_READ);

  assign key_reg = {store_q[MSB] ^ signed_mode, store_q[MSB-1:0]};
  assign key_bus = {bus_in[MSB]  ^ signed_mode, bus_in[MSB-1:0]};
  assign same    = (store_q == bus_in);
  assign above   = (key_reg > key_bus);

  always_comb begin
    if (stat_en_n) begin
      eq_o = 1'b1; gt_o = 1'b1; lt_o = 1'b1;
    end else if (!chain_in) begin
      eq_o = same; gt_o = 1'b1; lt_o = 1'b1;
    end else begin
      eq_o = same;
      gt_o = !same && above;
      lt_o = !same && !above;
    end
  end

  assign eq_drv = ~eq_o;
  assign gt_drv = ~gt_o;
  assign lt_drv = ~lt_o;

  assign chain_out = (op_sel == OP_SHIFT) ? store_q[0] : (chain_in & same);

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == OP_HOLD |=> bus_out == $past(bus_out)); // R2
  AST_SHIFT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == OP_SHIFT |=> bus_out[MSB] == $past(chain_in)); // R3
  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == OP_SHIFT |=> bus_out[MSB-1:0] == $past(bus_out[MSB:1])); // R3
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == OP_LOAD |=> bus_out == $past(bus_in)); // R4
  AST_RELEASED_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    stat_en_n |-> !eq_drv && !gt_drv && !lt_drv); // R6
  AST_LOW_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    !chain_in |-> !gt_drv && !lt_drv); // R7
  AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_en_n && chain_in) |-> $countones({eq_o, gt_o, lt_o}) == 1); // R8
  AST_CHAIN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel != OP_SHIFT && chain_out) |-> bus_in == bus_out); // R10

endmodule

// File: tb/regcmp_slice_test.sv
module regcmp_slice_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] op_sel;
  logic [7:0] bus_in, bus_out;
  logic       bus_oe, chain_in, chain_out, stat_en_n, signed_mode;
  logic       eq_o, gt_o, lt_o, eq_drv, gt_drv, lt_drv;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  regcmp_slice uut (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .chain_in(chain_in), .chain_out(chain_out), .stat_en_n(stat_en_n),
    .signed_mode(signed_mode), .eq_o(eq_o), .gt_o(gt_o), .lt_o(lt_o),
    .eq_drv(eq_drv), .gt_drv(gt_drv), .lt_drv(lt_drv)
  );

  // {signed_mode, stat_en_n, chain_in, reg, bus, eq, gt, lt, chain_out}
  localparam int NV = 12;
  localparam logic [22:0] VEC [NV] = '{
    {3'b001, 8'd50,  8'd30,  4'b0100},
    {3'b001, 8'd30,  8'd50,  4'b0010},
    {3'b001, 8'd77,  8'd77,  4'b1001},
    {3'b001, 8'h80,  8'h7F,  4'b0100},
    {3'b101, 8'h80,  8'h7F,  4'b0010},
    {3'b101, 8'hFF,  8'h01,  4'b0010},
    {3'b001, 8'hFF,  8'h01,  4'b0100},
    {3'b000, 8'd50,  8'd30,  4'b0110},
    {3'b000, 8'd77,  8'd77,  4'b1110},
    {3'b011, 8'd50,  8'd30,  4'b1110},
    {3'b011, 8'd77,  8'd77,  4'b1111},
    {3'b101, 8'h00,  8'h00,  4'b1001}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_sel = 2'b11; bus_in = 8'hC3; chain_in = 1'b1;
    stat_en_n = 1'b0; signed_mode = 1'b0;
    tick(); tick();
    rst_n = 1'b1; op_sel = 2'b01;
    #1;
    check("R1 reset value", {24'd0, bus_out}, 32'h00);
    check("R5 read oe", {31'd0, bus_oe}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      op_sel = 2'b11; bus_in = VEC[i][19:12];
      tick();
      op_sel = 2'b00; bus_in = VEC[i][11:4];
      signed_mode = VEC[i][22]; stat_en_n = VEC[i][21]; chain_in = VEC[i][20];
      #1;
      check($sformatf("R6 R7 R8 R9 R10 vector %0d", i),
            {28'd0, eq_o, gt_o, lt_o, chain_out}, {28'd0, VEC[i][3:0]});
      check($sformatf("R11 drive vector %0d", i),
            {29'd0, eq_drv, gt_drv, lt_drv}, {29'd0, ~VEC[i][3:1]});
      check($sformatf("R5 oe off vector %0d", i), {31'd0, bus_oe}, 32'd0);
    end

    stat_en_n = 1'b0; signed_mode = 1'b0;
    op_sel = 2'b11; bus_in = 8'hA5;
    tick();
    op_sel = 2'b10; chain_in = 1'b1;
    #1;
    check("R3 serial out bit0 before", {31'd0, chain_out}, 32'd1);
    tick();
    check("R3 serial out after first shift", {31'd0, chain_out}, 32'd0);
    chain_in = 1'b0;
    tick();
    check("R3 serial out after second shift", {31'd0, chain_out}, 32'd1);
    op_sel = 2'b01;
    #1;
    check("R3 shifted value", {24'd0, bus_out}, 32'h69);
    op_sel = 2'b00; bus_in = 8'h12;
    tick(); tick();
    op_sel = 2'b01;
    #1;
    check("R2 hold keeps value", {24'd0, bus_out}, 32'h69);
    op_sel = 2'b11; bus_in = 8'h3C;
    tick();
    op_sel = 2'b01;
    #1;
    check("R4 load value", {24'd0, bus_out}, 32'h3C);
    op_sel = 2'b11; rst_n = 1'b0; bus_in = 8'hEE;
    tick();
    rst_n = 1'b1; op_sel = 2'b01;
    #1;
    check("R1 reset overrides load", {24'd0, bus_out}, 32'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule